// File: doc/BRIEF.md
# Read-After-Write Pacing Bridge

This bridge connects a processor-side request port (valid/ready with address, direction and write data) to an asynchronous-style programmed I/O peripheral bus with an active-low chip select, read strobe and write strobe. Some peripheral status registers only reflect a write some time after the write strobe ends. The bridge therefore keeps a minimum gap, which depends on the register being read, between the end of the most recent write and the start of a following read.

The gap can be covered in two ways, chosen by `modeDummy`. The bridge can hold the request and leave the bus idle. It can also fill the gap with back-to-back reads of a fixed byte-order test register, and it discards their data. The bridge also follows the peripheral's lockout after reset: after the bridge or the peripheral has been reset, it performs one test-register read before it forwards the first write. A bus cycle during which the peripheral reset is active is dropped and retried.

Each request completes on the clock where its bus cycle ends. For a read, the data is presented in that same clock.

Top module: `rw_pacing_bridge`

## Requirements
- R1: While `rstN` is low, and on the first clock after it, `busCsN`, `busRdN` and `busWrN` are high and `reqReady` and `rspValid` are low.
- R2: After `rstN` has been released, and after any clock with `periphResetN` low, the bridge completes one read of the test register (address 0x64) before it drives `busWrN` low. It does this only if no read has completed since that reset. No write issued by the bridge is lost to the lockout.
- R3: If `periphResetN` is low in any clock of a bus cycle, that cycle is not acknowledged. A read returns no data and the cycle is repeated once the peripheral reset is high again.
- R4: The gap is counted in clocks from the first clock with `busWrN` high after a write to the first clock with `busRdN` low for a read. It is at least the register's wait: 0 clocks for the receive-data address 0x00, ceil(135 ns / clock period) = 7 clocks for the transmit-level status address 0x80, and ceil(45 ns / clock period) = 3 clocks for any other address.
- R5: With `modeDummy` low, an early read is stalled with the bus idle. No extra bus cycles are issued, and the read strobe falls in the first clock that meets the wait.
- R6: With `modeDummy` high, an early read is preceded by back-to-back test-register reads, each STROBE_CLK+1 clocks long. They stop as soon as the next strobe can meet the wait, so the real strobe falls at most STROBE_CLK clocks after the wait is met.
- R7: Data from test-register reads that the bridge itself inserts never appears on the response port. Each accepted read yields exactly one `rspValid`.
- R8: A read of a zero-wait register issued right after a write inserts no extra bus cycle. Its strobe falls on the clock after the request is first seen.
- R9: A read whose wait has already run out is issued with no added delay. `busRdN` falls on the clock after `reqValid` is first seen high.
- R10: Each bus cycle holds `busCsN` and exactly one strobe low for STROBE_CLK clocks (2 by default), with the address held steady.
- R11: `reqReady` is high in the last strobe clock of an acknowledged cycle. For a read, `rspValid` is high in that same clock and `rspData` carries the peripheral's read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset of the bridge |
| periphResetN | input | 1 | Active-low peripheral reset indication |
| modeDummy | input | 1 | 1: cover waits with test-register reads; 0: stall |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request done (handshake) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | AW | Register address |
| reqWdata | input | DW | Write data |
| rspValid | output | 1 | Read data valid |
| rspData | output | DW | Read data |
| busCsN | output | 1 | Chip select, active low |
| busRdN | output | 1 | Read strobe, active low |
| busWrN | output | 1 | Write strobe, active low |
| busAddr | output | AW | Bus address |
| busWdata | output | DW | Bus write data |
| busRdata | input | DW | Bus read data |

## Verification
The assertions assume that the requester holds `reqAddr`, `reqWrite` and `reqWdata` steady from the clock `reqValid` rises until the handshake. They also assume that `busRdata` stays stable while the read strobe is low, because the gap and response checks compare values across those clocks. The driver changes request fields only on falling clock edges, and never while a request is outstanding. The peripheral model changes its read data only on the first falling edge of each read strobe. Peripheral reset pulses are placed between rising edges, so the bridge and the model see them in the same clocks.

// File: rtl/pace_pkg.sv
package pace_pkg;
  // Strobes from the control FSM to the bus datapath.
  typedef struct packed {
    logic active;   // a bus cycle is in progress
    logic isWrite;  // cycle is a write
    logic isDummy;  // cycle is an inserted test-register read
  } busCtl_t;
endpackage

// File: rtl/pace_ctl.sv
module pace_ctl
  import pace_pkg::*;
#(
  parameter int STROBE_CLK = 2,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          periphResetN,
  input  logic          modeDummy,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic [CW-1:0] needCyc,
  output logic          reqReady,
  output busCtl_t       ctl
);
  localparam int SW = (STROBE_CLK > 1) ? $clog2(STROBE_CLK) : 1;
  localparam logic [CW-1:0] SAT = {CW{1'b1}};

  typedef enum logic {ST_IDLE, ST_STROBE} state_t;
  state_t state;

  logic [SW-1:0] strobeCnt;
  logic          opWrite, opDummy, tainted, unlocked;
  logic [CW-1:0] sinceWr;     // clocks since the last write strobe ended
  logic          lastCyc, okNow, waitMet;
  logic          startWrite, startRead, startDummy;

  always_comb begin
    lastCyc    = (state == ST_STROBE) && (strobeCnt == SW'(STROBE_CLK - 1));
    okNow      = !tainted && periphResetN;
    waitMet    = ({1'b0, sinceWr} + (CW+1)'(1)) >= {1'b0, needCyc};
    startWrite = 1'b0;
    startRead  = 1'b0;
    startDummy = 1'b0;
    if (state == ST_IDLE && reqValid && periphResetN) begin
      if (reqWrite) begin
        if (unlocked) startWrite = 1'b1;
        else          startDummy = 1'b1;
      end else if (waitMet) begin
        startRead = 1'b1;
      end else if (modeDummy) begin
        startDummy = 1'b1;
      end
    end
    reqReady    = lastCyc && !opDummy && okNow;
    ctl.active  = (state == ST_STROBE);
    ctl.isWrite = opWrite;
    ctl.isDummy = opDummy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      strobeCnt <= '0;
      opWrite   <= 1'b0;
      opDummy   <= 1'b0;
      tainted   <= 1'b0;
      unlocked  <= 1'b0;
      sinceWr   <= SAT;
    end else begin
      if (sinceWr != SAT) sinceWr <= sinceWr + CW'(1);
      if (state == ST_IDLE) begin
        if (startWrite || startRead || startDummy) begin
          state     <= ST_STROBE;
          strobeCnt <= '0;
          opWrite   <= startWrite;
          opDummy   <= startDummy;
          tainted   <= 1'b0;
        end
      end else begin
        if (!periphResetN) tainted <= 1'b1;
        if (lastCyc) begin
          state <= ST_IDLE;
          if (okNow) begin
            if (opWrite) sinceWr  <= '0;
            else         unlocked <= 1'b1;
          end
        end else begin
          strobeCnt <= strobeCnt + SW'(1);
        end
      end
      if (!periphResetN) unlocked <= 1'b0;
    end
  end

  // R4: a real read strobe starts only once the register's wait has elapsed
  a_r4_gap_met: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STROBE && strobeCnt == '0 && !opWrite && !opDummy) |-> (sinceWr >= needCyc));
  // R2: a write strobe only ever starts while the lockout is cleared
  a_r2_write_unlocked: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STROBE && opWrite && strobeCnt == '0) |-> unlocked);
  // R3: no handshake while the peripheral is in reset
  a_r3_no_ack_in_reset: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STROBE && !periphResetN) |-> !reqReady);
  // R10: strobe counter stays within the configured strobe length
  a_r10_strobe_len: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STROBE) |-> (int'(strobeCnt) < STROBE_CLK));
endmodule

// File: rtl/pace_dp.sv
module pace_dp
  import pace_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int CW = 5,
  parameter int CLK_NS = 20,
  parameter int TXSTAT_WAIT_NS = 135,
  parameter int OTHER_WAIT_NS = 45,
  parameter logic [AW-1:0] RXFIFO_ADDR = 8'h00,
  parameter logic [AW-1:0] TXSTAT_ADDR = 8'h80,
  parameter logic [AW-1:0] TEST_ADDR = 8'h64
) (
  input  logic          clk,
  input  logic          rstN,
  input  busCtl_t       ctl,
  input  logic          reqReady,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  output logic [CW-1:0] needCyc,
  output logic          rspValid,
  output logic [DW-1:0] rspData,
  output logic          busCsN,
  output logic          busRdN,
  output logic          busWrN,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busWdata,
  input  logic [DW-1:0] busRdata
);
  localparam int TX_CLK    = (TXSTAT_WAIT_NS + CLK_NS - 1) / CLK_NS;
  localparam int OTHER_CLK = (OTHER_WAIT_NS + CLK_NS - 1) / CLK_NS;

  // Per-register wait lookup, in clocks
  always_comb begin
    if (reqAddr == RXFIFO_ADDR)      needCyc = '0;
    else if (reqAddr == TXSTAT_ADDR) needCyc = CW'(TX_CLK);
    else                             needCyc = CW'(OTHER_CLK);
  end

  always_comb begin
    busCsN   = !ctl.active;
    busRdN   = !(ctl.active && !ctl.isWrite);
    busWrN   = !(ctl.active && ctl.isWrite);
    busAddr  = ctl.isDummy ? TEST_ADDR : reqAddr;
    busWdata = (ctl.active && ctl.isWrite) ? reqWdata : '0;
    rspValid = reqReady && !reqWrite;
    rspData  = busRdata;
  end

  // R7: a response only comes from a live read of the requested register
  a_r7_rsp_real: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (!busRdN && busAddr == reqAddr));
  // R10: address held steady while chip select stays low
  a_r10_addr_steady: assert property (@(posedge clk) disable iff (!rstN)
    (!busCsN && $past(!busCsN)) |-> $stable(busAddr));
endmodule

// File: rtl/rw_pacing_bridge.sv
module rw_pacing_bridge
  import pace_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int CLK_NS = 20,
  parameter int STROBE_CLK = 2,
  parameter int TXSTAT_WAIT_NS = 135,
  parameter int OTHER_WAIT_NS = 45,
  parameter logic [AW-1:0] RXFIFO_ADDR = 8'h00,
  parameter logic [AW-1:0] TXSTAT_ADDR = 8'h80,
  parameter logic [AW-1:0] TEST_ADDR = 8'h64
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          periphResetN,
  input  logic          modeDummy,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  output logic          rspValid,
  output logic [DW-1:0] rspData,
  output logic          busCsN,
  output logic          busRdN,
  output logic          busWrN,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busWdata,
  input  logic [DW-1:0] busRdata
);
  localparam int TX_CLK    = (TXSTAT_WAIT_NS + CLK_NS - 1) / CLK_NS;
  localparam int OTHER_CLK = (OTHER_WAIT_NS + CLK_NS - 1) / CLK_NS;
  localparam int MAX_CLK   = (TX_CLK > OTHER_CLK) ? TX_CLK : OTHER_CLK;
  localparam int CW        = $clog2(MAX_CLK + 2) + 1;

  busCtl_t       ctl;
  logic [CW-1:0] needCyc;

  pace_ctl #(.STROBE_CLK(STROBE_CLK), .CW(CW)) u_ctl (
    .clk(clk), .rstN(rstN), .periphResetN(periphResetN), .modeDummy(modeDummy),
    .reqValid(reqValid), .reqWrite(reqWrite), .needCyc(needCyc),
    .reqReady(reqReady), .ctl(ctl)
  );

  pace_dp #(
    .AW(AW), .DW(DW), .CW(CW), .CLK_NS(CLK_NS),
    .TXSTAT_WAIT_NS(TXSTAT_WAIT_NS), .OTHER_WAIT_NS(OTHER_WAIT_NS),
    .RXFIFO_ADDR(RXFIFO_ADDR), .TXSTAT_ADDR(TXSTAT_ADDR), .TEST_ADDR(TEST_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .needCyc(needCyc),
    .rspValid(rspValid), .rspData(rspData),
    .busCsN(busCsN), .busRdN(busRdN), .busWrN(busWrN),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata)
  );
endmodule

// File: tb/rw_pacing_bridge_test.sv
`timescale 1ns/1ps
module rw_pacing_bridge_test;
  localparam logic [7:0] A_RX   = 8'h00;
  localparam logic [7:0] A_TXST = 8'h80;
  localparam logic [7:0] A_TXD  = 8'h20;
  localparam logic [7:0] A_TEST = 8'h64;
  localparam logic [31:0] TEST_PAT = 32'h1357_9BDF;

  logic clk = 1'b0;
  logic rstN = 1'b0, periphResetN = 1'b1, modeDummy = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [7:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic reqReady, rspValid, busCsN, busRdN, busWrN;
  logic [31:0] rspData, busWdata, busRdata;
  logic [7:0] busAddr;

  always #10 clk = ~clk;  // 50 MHz

  rw_pacing_bridge uut (
    .clk(clk), .rstN(rstN), .periphResetN(periphResetN), .modeDummy(modeDummy),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspValid(rspValid), .rspData(rspData),
    .busCsN(busCsN), .busRdN(busRdN), .busWrN(busWrN), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata)
  );

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- peripheral model ----------------
  logic [31:0] regs [0:255];
  logic [31:0] rdLatch = '0, wrDataL = '0;
  logic [7:0]  wrAddrL = '0;
  logic locked = 1'b1, prevRd = 1'b1, prevWr = 1'b1, rdTaint = 1'b0;
  int cyc = 0, wrRise = -1000, lastGap = 0, lastLen = 0, lenCnt = 0;
  int testReads = 0, realReads = 0, lostWrites = 0, txLevel = 0, txPrev = 0, rxCount = 0;
  assign busRdata = rdLatch;

  always @(negedge clk) begin
    cyc++;
    if (!rstN || !periphResetN) locked = 1'b1;
    if (!busRdN && !periphResetN) rdTaint = 1'b1;
    if (prevRd && !busRdN) begin
      lenCnt = 1;
      rdTaint = !periphResetN;
      if (busAddr == A_TEST) begin
        testReads++;
        rdLatch = TEST_PAT;
      end else begin
        realReads++;
        lastGap = cyc - wrRise;
        if (busAddr == A_TXST) rdLatch = (lastGap * 20 >= 135) ? txLevel : txPrev;
        else if (busAddr == A_RX) begin rdLatch = 32'hA000_0000 + rxCount; rxCount++; end
        else rdLatch = regs[busAddr];
      end
    end else if (!busRdN) lenCnt++;
    if (!prevRd && busRdN) begin
      lastLen = lenCnt;
      if (!rdTaint && periphResetN) locked = 1'b0;
    end
    if (!busWrN) begin wrAddrL = busAddr; wrDataL = busWdata; end
    if (!prevWr && busWrN) begin
      wrRise = cyc;
      if (locked) lostWrites++;
      else if (wrAddrL == A_TXD) begin txPrev = txLevel; txLevel++; end
      else regs[wrAddrL] = wrDataL;
    end
    prevRd = busRdN;
    prevWr = busWrN;
  end

  // ---------------- scoreboard ----------------
  logic [31:0] expQ[$];
  int rspCount = 0, readsIssued = 0;

  always @(negedge clk) begin
    if (rstN && rspValid) begin
      rspCount++;
      if (expQ.size() == 0) check(1'b0, "R7 unexpected response", rspData, 32'h0);
      else begin
        logic [31:0] e;
        e = expQ.pop_front();
        check(rspData == e, "R11 read data", rspData, e);
      end
    end
  end

  task automatic issue(input bit w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d;
    do @(negedge clk); while (!reqReady);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    issue(1'b1, a, d);
  endtask

  task automatic doRead(input logic [7:0] a, input logic [31:0] e);
    expQ.push_back(e);
    readsIssued++;
    issue(1'b0, a, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int tr0, rr0;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(busCsN && busRdN && busWrN, "R1 strobes idle in reset", {busCsN, busRdN, busWrN}, 3'b111);
    check(!reqReady && !rspValid, "R1 no handshake in reset", {reqReady, rspValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busCsN && busRdN && busWrN && !reqReady, "R1 idle after release", {busCsN, busRdN, busWrN}, 3'b111);

    // R2: first write after reset is preceded by a test-register read
    tr0 = testReads;
    doWrite(8'h10, 32'h1111_2222);
    check(testReads - tr0 == 1, "R2 unlock read before first write", testReads - tr0, 1);
    check(lostWrites == 0, "R2 no write lost", lostWrites, 0);
    doRead(8'h10, 32'h1111_2222);
    check(lastLen == 2, "R10 strobe length", lastLen, 2);

    // R5: stall mode, TX status right after TX data write
    modeDummy = 1'b0;
    doWrite(A_TXD, 32'h0);
    tr0 = testReads;
    doRead(A_TXST, 32'd1);
    check(testReads == tr0, "R5 no bus cycles while stalling", testReads - tr0, 0);
    check(lastGap == 7, "R4 R5 status gap exact in stall mode", lastGap, 7);

    // R6: dummy mode, same pattern; request seen at gap 1 -> dummies at 2..3, 5..6, real at 8
    modeDummy = 1'b1;
    doWrite(A_TXD, 32'h0);
    tr0 = testReads;
    doRead(A_TXST, 32'd2);
    check(testReads - tr0 == 2, "R6 dummy count for status", testReads - tr0, 2);
    check(lastGap >= 7 && lastGap <= 9, "R4 R6 status gap in dummy mode", lastGap, 8);

    // R8: zero-wait receive data read right after a write
    doWrite(8'h14, 32'h0000_ABCD);
    tr0 = testReads;
    doRead(A_RX, 32'hA000_0000);
    check(testReads == tr0, "R8 no dummies for zero-wait read", testReads - tr0, 0);
    check(lastGap == 2, "R8 strobe on clock after request", lastGap, 2);

    // R4: default-wait register, stall mode
    modeDummy = 1'b0;
    doWrite(8'h18, 32'h5555_0000);
    doRead(8'h14, 32'h0000_ABCD);
    check(lastGap == 3, "R4 default wait gap", lastGap, 3);

    // R6: default-wait register, dummy mode: one dummy then real at gap 5
    modeDummy = 1'b1;
    doWrite(8'h18, 32'h5555_1111);
    tr0 = testReads;
    doRead(8'h18, 32'h5555_1111);
    check(testReads - tr0 == 1, "R6 dummy count for default register", testReads - tr0, 1);
    check(lastGap == 5, "R6 default gap in dummy mode", lastGap, 5);

    // R9: read after the wait has expired goes out at once
    doWrite(8'h1C, 32'hCAFE_0001);
    repeat (20) @(negedge clk);
    tr0 = testReads;
    expQ.push_back(32'hCAFE_0001);
    readsIssued++;
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 8'h1C;
    @(negedge clk);
    check(!busRdN && busAddr == 8'h1C, "R9 strobe on next clock", {busRdN, busAddr}, {1'b0, 8'h1C});
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(testReads == tr0, "R9 no dummies after expiry", testReads - tr0, 0);

    // R3: peripheral reset across a read -> dropped and retried
    modeDummy = 1'b0;
    rr0 = realReads;
    fork
      doRead(8'h10, 32'h1111_2222);
      begin
        do @(negedge clk); while (busRdN);
        @(posedge clk); #1 periphResetN = 1'b0;
        @(posedge clk); #1 periphResetN = 1'b1;
      end
    join
    check(realReads - rr0 == 2, "R3 read retried after reset", realReads - rr0, 2);

    // R2: idle peripheral reset re-arms the lockout
    @(posedge clk); #1 periphResetN = 1'b0;
    repeat (2) @(posedge clk);
    #1 periphResetN = 1'b1;
    tr0 = testReads;
    doWrite(8'h30, 32'h7777_7777);
    check(testReads - tr0 == 1, "R2 unlock read after peripheral reset", testReads - tr0, 1);
    check(lostWrites == 0, "R2 no write lost after peripheral reset", lostWrites, 0);
    doRead(8'h30, 32'h7777_7777);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R7 all reads answered", expQ.size(), 0);
    check(rspCount == readsIssued, "R7 one response per read", rspCount, readsIssued);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule